// File: doc/BRIEF.md
# Super Pixel Cluster Packetizer

The block serves a 4 x 4 group of pixels. It turns the discriminator hits that start in one bunch crossing into a single cluster packet. Every pixel in the group drives a level-sensitive hit strobe. A pixel whose strobe rises while the block is idle opens a cluster. The cluster stamps the current 12-bit bunch counter, and each member pixel then measures its own time over threshold. The cluster closes once every member pixel has dropped its strobe. All hits in the cluster share one header, which carries the bunch stamp, the super-pixel address and a 16-bit hit map. Each hit pixel adds a 4-bit time-over-threshold nibble.

Closed clusters go into a local store that holds two clusters of any size. The store drains in arrival order through a valid/ready port toward a second-stage column buffer. Each packet leaves as one header beat followed by one data beat per hit pixel.

Two conditions drop a cluster before it is stored. The first is a programmable hit-count threshold. The second is a dead state, which holds while both slots are full. A saturating counter reports the dropped clusters. A merge-enable bit controls a boundary flag in the header, which lets a downstream stage join the cluster with the one in the neighbouring super pixel below it.

Top module: `sp_cluster_pack`

## Requirements
- R1: After reset, `pkt_valid_o` is 0 and `lost_cnt_o` is 0.
- R2: Pixel index p = row*4 + column maps to hit-map bit p. While the block is idle, the strobes that rise on the same clock edge form one cluster. The header beat (`pkt_hdr_o`=1) carries bit 34 = boundary flag, bits 33:28 = `sp_addr_i`, bits 27:16 = `bcid_i` as sampled on the opening edge, and bits 15:0 = hit map.
- R3: A pixel's ToT is the number of clock edges on which its strobe is sampled high, counted from the opening edge. The ToT saturates at 15.
- R4: After the header come exactly one data beat per set hit-map bit, in ascending pixel index. Each data beat has `pkt_hdr_o`=0, the ToT in bits 3:0 and zeros above. `pkt_last_o` is 1 only on the final data beat.
- R5: A cluster closes on the first edge on which none of its member pixels is sampled high. Strobes that rise while a cluster is open add nothing to any packet and are not counted as lost.
- R6: A cluster whose hit count is greater than `thr_i` is discarded and produces no beat. A cluster whose hit count equals `thr_i` is kept.
- R7: When both slots are occupied on the edge where strobes rise, those strobes are ignored and produce no packet.
- R8: Stored clusters leave in arrival order. A slot becomes free on the edge where its last beat is accepted, and from then on a new cluster is captured again.
- R9: The boundary flag is 1 only when `merge_en_i` is 1 and the cluster has a hit in pixels 0 to 3. With merging off, the flag is always 0.
- R10: `lost_cnt_o` increments by one for each cluster dropped under R6 or R7, and saturates at its maximum.
- R11: While `pkt_valid_o` is 1 and `pkt_ready_i` is 0, the beat on the next cycle keeps `pkt_valid_o` at 1 and leaves `pkt_data_o`, `pkt_hdr_o` and `pkt_last_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch-crossing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | 16 | Per-pixel discriminator strobes |
| bcid_i | input | 12 | Bunch counter |
| sp_addr_i | input | 6 | Super-pixel address |
| thr_i | input | 5 | Largest hit count that is kept |
| merge_en_i | input | 1 | Enables the boundary flag |
| pkt_valid_o | output | 1 | Beat valid |
| pkt_ready_i | input | 1 | Beat accepted by downstream |
| pkt_hdr_o | output | 1 | Beat is a header |
| pkt_last_o | output | 1 | Final data beat of a packet |
| pkt_data_o | output | 35 | Header word or ToT nibble |
| lost_cnt_o | output | 8 | Saturating count of dropped clusters |

## Verification
A corrupted done mask or capture state shows up at the ports as a wrong hit map or a wrong ToT nibble. The first header or data beat after the cluster closes exposes it. A slot pointer or occupancy error appears as reordered, repeated or missing packets, or as a cluster that is wrongly dropped or kept in the dead state. The first packet popped after the error reveals it, and `lost_cnt_o` shows it in the next cycle. A serializer fault breaks the beat count, the last-beat marking or the stability of the held beat on the very cycle it happens.

// File: rtl/sp_pkg.sv
package sp_pkg;
  parameter int unsigned NPIX   = 16;
  parameter int unsigned TOT_W  = 4;
  parameter int unsigned BCID_W = 12;
  parameter int unsigned ADDR_W = 6;
  parameter int unsigned SLOTS  = 2;
  parameter int unsigned LOST_W = 8;
  localparam int unsigned HDR_W = 1 + ADDR_W + BCID_W + NPIX;
  localparam int unsigned ENT_W = HDR_W + NPIX * TOT_W;
  localparam int unsigned CNT_W = $clog2(NPIX + 1);
endpackage

// File: rtl/sp_capture.sv
module sp_capture #(
  parameter int unsigned NPIX   = sp_pkg::NPIX,
  parameter int unsigned TOT_W  = sp_pkg::TOT_W,
  parameter int unsigned BCID_W = sp_pkg::BCID_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NPIX-1:0]         hit_i,
  input  logic [BCID_W-1:0]       bcid_i,
  input  logic                    open_ok_i,
  output logic                    close_o,
  output logic                    dead_o,
  output logic [NPIX-1:0]         map_o,
  output logic [NPIX*TOT_W-1:0]   tot_o,
  output logic [BCID_W-1:0]       bcid_o
);
  localparam logic [TOT_W-1:0] TOT_MAX = {TOT_W{1'b1}};

  logic [NPIX-1:0]   hit_q, map_q, act_w, rise_w;
  logic [BCID_W-1:0] bcid_q;
  logic              busy_q, start_w;

  assign rise_w  = hit_i & ~hit_q;
  assign start_w = !busy_q && (|rise_w) && open_ok_i;
  assign dead_o  = !busy_q && (|rise_w) && !open_ok_i;
  // closes once no still-active member is sampled high
  assign close_o = busy_q && ((act_w & hit_i) == '0);
  assign map_o   = map_q;
  assign bcid_o  = bcid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= '0;
      map_q  <= '0;
      bcid_q <= '0;
      busy_q <= 1'b0;
    end else begin
      hit_q <= hit_i;
      if (start_w) begin
        busy_q <= 1'b1;
        map_q  <= rise_w;
        bcid_q <= bcid_i;
      end else if (close_o) begin
        busy_q <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NPIX; g++) begin : g_pix
    logic [TOT_W-1:0] cnt_q;
    logic             done_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q  <= '0;
        done_q <= 1'b1;
      end else if (start_w) begin
        cnt_q  <= rise_w[g] ? TOT_W'(1) : '0;
        done_q <= !rise_w[g];
      end else if (busy_q && !done_q) begin
        if (hit_i[g]) begin
          if (cnt_q != TOT_MAX) cnt_q <= cnt_q + TOT_W'(1);
        end else begin
          done_q <= 1'b1;
        end
      end
    end
    assign act_w[g] = !done_q;
    assign tot_o[g*TOT_W +: TOT_W] = cnt_q;
  end

  p_close_nonempty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_o |-> (map_q != '0));
  p_late_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !close_o) |=> $stable(map_q) && $stable(bcid_q));
endmodule

// File: rtl/sp_slot_fifo.sv
module sp_slot_fifo #(
  parameter int unsigned W     = sp_pkg::ENT_W,
  parameter int unsigned DEPTH = sp_pkg::SLOTS
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic [W-1:0]                 din_i,
  input  logic                         pop_i,
  output logic [W-1:0]                 dout_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  assign dout_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= din_i;
        wr_q <= (wr_q == LAST) ? '0 : wr_q + PW'(1);
      end
      if (pop_i) rd_q <= (rd_q == LAST) ? '0 : rd_q + PW'(1);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_q < CW'(DEPTH)));
  p_no_underflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));
endmodule

// File: rtl/sp_serializer.sv
module sp_serializer #(
  parameter int unsigned NPIX  = sp_pkg::NPIX,
  parameter int unsigned TOT_W = sp_pkg::TOT_W,
  parameter int unsigned HDR_W = sp_pkg::HDR_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   head_vld_i,
  input  logic [HDR_W-1:0]       head_hdr_i,
  input  logic [NPIX*TOT_W-1:0]  head_tot_i,
  output logic                   pop_o,
  output logic                   valid_o,
  input  logic                   ready_i,
  output logic                   hdr_o,
  output logic                   last_o,
  output logic [HDR_W-1:0]       data_o
);
  localparam int unsigned IW = $clog2(NPIX);

  logic            in_data_q;
  logic [NPIX-1:0] rem_q, rem_next;
  logic [IW-1:0]   idx_w;
  logic            fire_w;

  always_comb begin
    idx_w = '0;
    for (int i = NPIX - 1; i >= 0; i--) if (rem_q[i]) idx_w = IW'(i);
  end

  assign rem_next = rem_q & (rem_q - NPIX'(1));
  assign valid_o  = head_vld_i;
  assign fire_w   = valid_o && ready_i;
  assign hdr_o    = !in_data_q;
  assign last_o   = in_data_q && (rem_next == '0);
  assign data_o   = in_data_q ? HDR_W'(head_tot_i[idx_w*TOT_W +: TOT_W]) : head_hdr_i;
  assign pop_o    = fire_w && last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_data_q <= 1'b0;
      rem_q     <= '0;
    end else if (fire_w) begin
      if (!in_data_q) begin
        in_data_q <= 1'b1;
        rem_q     <= head_hdr_i[NPIX-1:0];
      end else begin
        rem_q <= rem_next;
        if (last_o) in_data_q <= 1'b0;
      end
    end
  end

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> valid_o && $stable(data_o) && $stable(hdr_o) && $stable(last_o));
  p_last_is_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && last_o) |-> !hdr_o);
endmodule

// File: rtl/sp_cluster_pack.sv
module sp_cluster_pack #(
  parameter int unsigned NPIX   = sp_pkg::NPIX,
  parameter int unsigned TOT_W  = sp_pkg::TOT_W,
  parameter int unsigned BCID_W = sp_pkg::BCID_W,
  parameter int unsigned ADDR_W = sp_pkg::ADDR_W,
  parameter int unsigned SLOTS  = sp_pkg::SLOTS,
  parameter int unsigned LOST_W = sp_pkg::LOST_W,
  parameter int unsigned ROW_W  = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [NPIX-1:0]                    hit_i,
  input  logic [BCID_W-1:0]                  bcid_i,
  input  logic [ADDR_W-1:0]                  sp_addr_i,
  input  logic [$clog2(NPIX+1)-1:0]          thr_i,
  input  logic                               merge_en_i,
  output logic                               pkt_valid_o,
  input  logic                               pkt_ready_i,
  output logic                               pkt_hdr_o,
  output logic                               pkt_last_o,
  output logic [1+ADDR_W+BCID_W+NPIX-1:0]    pkt_data_o,
  output logic [LOST_W-1:0]                  lost_cnt_o
);
  localparam int unsigned HDR_W = 1 + ADDR_W + BCID_W + NPIX;
  localparam int unsigned TOT_V = NPIX * TOT_W;
  localparam int unsigned ENT_W = HDR_W + TOT_V;
  localparam int unsigned CNT_W = $clog2(NPIX + 1);
  localparam int unsigned OCC_W = $clog2(SLOTS + 1);
  localparam logic [LOST_W-1:0] LOST_MAX = {LOST_W{1'b1}};

  logic              close_w, dead_w, push_w, pop_w, thr_drop_w, drop_w, edge_w;
  logic [NPIX-1:0]   map_w;
  logic [TOT_V-1:0]  tot_w;
  logic [BCID_W-1:0] bcid_w;
  logic [CNT_W-1:0]  nhit_w;
  logic [ENT_W-1:0]  din_w, dout_w;
  logic [OCC_W-1:0]  occ_w;
  logic [LOST_W-1:0] lost_q;

  sp_capture #(.NPIX(NPIX), .TOT_W(TOT_W), .BCID_W(BCID_W)) u_capture (
    .clk_i, .rst_ni, .hit_i, .bcid_i,
    .open_ok_i (occ_w != OCC_W'(SLOTS)),
    .close_o   (close_w),
    .dead_o    (dead_w),
    .map_o     (map_w),
    .tot_o     (tot_w),
    .bcid_o    (bcid_w)
  );

  always_comb begin
    nhit_w = '0;
    for (int i = 0; i < NPIX; i++) nhit_w = nhit_w + CNT_W'(map_w[i]);
  end

  assign edge_w     = merge_en_i && (|map_w[ROW_W-1:0]);
  assign thr_drop_w = close_w && (nhit_w > thr_i);
  assign push_w     = close_w && !thr_drop_w;
  assign drop_w     = thr_drop_w || dead_w;
  assign din_w      = {edge_w, sp_addr_i, bcid_w, map_w, tot_w};

  sp_slot_fifo #(.W(ENT_W), .DEPTH(SLOTS)) u_slots (
    .clk_i, .rst_ni,
    .push_i  (push_w),
    .din_i   (din_w),
    .pop_i   (pop_w),
    .dout_o  (dout_w),
    .count_o (occ_w)
  );

  sp_serializer #(.NPIX(NPIX), .TOT_W(TOT_W), .HDR_W(HDR_W)) u_ser (
    .clk_i, .rst_ni,
    .head_vld_i (occ_w != '0),
    .head_hdr_i (dout_w[ENT_W-1:TOT_V]),
    .head_tot_i (dout_w[TOT_V-1:0]),
    .pop_o      (pop_w),
    .valid_o    (pkt_valid_o),
    .ready_i    (pkt_ready_i),
    .hdr_o      (pkt_hdr_o),
    .last_o     (pkt_last_o),
    .data_o     (pkt_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          lost_q <= '0;
    else if (drop_w && lost_q != LOST_MAX) lost_q <= lost_q + LOST_W'(1);
  end
  assign lost_cnt_o = lost_q;

  p_lost_inc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_w && lost_q != LOST_MAX) |=> (lost_q == $past(lost_q) + LOST_W'(1)));
  p_lost_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drop_w |=> $stable(lost_q));
  p_thr_no_store_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_drop_w |=> (occ_w == $past(occ_w) - OCC_W'($past(pop_w))));
endmodule

// File: tb/sp_cluster_pack_bench.sv
module sp_cluster_pack_bench;
  localparam logic [5:0] ADDR = 6'h2A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] hit = '0;
  logic [11:0] bcid = '0;
  logic [4:0]  thr = 5'd16;
  logic        merge_en = 1'b0;
  logic        ready = 1'b1;
  logic        valid, hdr, last;
  logic [34:0] data;
  logic [7:0]  lost;

  int n_chk = 0, n_fail = 0;
  int rmode = 0;
  logic [7:0] lfsr = 8'hA5;
  bit done = 0;
  int plen [16];

  logic [36:0] q_beat[$];
  string       q_req[$];

  always #2.5 clk = ~clk;

  sp_cluster_pack u_sp_cluster_pack (
    .clk_i(clk), .rst_ni(rst_n), .hit_i(hit), .bcid_i(bcid), .sp_addr_i(ADDR),
    .thr_i(thr), .merge_en_i(merge_en), .pkt_valid_o(valid), .pkt_ready_i(ready),
    .pkt_hdr_o(hdr), .pkt_last_o(last), .pkt_data_o(data), .lost_cnt_o(lost)
  );

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (rmode == 0) ready <= 1'b1;
    else if (rmode == 1) ready <= 1'b0;
    else ready <= lfsr[0];
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  logic        p_valid = 0, p_ready = 0;
  logic [36:0] p_beat = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_valid && !p_ready)
        chk(valid && {hdr, last, data} == p_beat, "R11 held beat", {27'd0, valid, hdr, last, data}, {27'd0, 1'b1, p_beat});
      if (valid && ready) begin
        if (q_beat.size() == 0) begin
          chk(0, "R6/R7 unexpected beat", {27'd0, hdr, last, data}, 64'd0);
        end else begin
          logic [36:0] e;
          string r;
          e = q_beat.pop_front();
          r = q_req.pop_front();
          chk({hdr, last, data} == e, r, {27'd0, hdr, last, data}, {27'd0, e});
        end
      end
      p_valid = valid; p_ready = ready; p_beat = {hdr, last, data};
    end
  end

  task automatic expect_pkt(input logic [15:0] mask, input logic [11:0] bc, input string req);
    logic flag;
    int   cnt = 0, seen = 0;
    flag = merge_en && (|mask[3:0]);
    q_beat.push_back({1'b1, 1'b0, flag, ADDR, bc, mask});
    q_req.push_back({req, " R2/R9 header"});
    for (int p = 0; p < 16; p++) if (mask[p]) cnt++;
    for (int p = 0; p < 16; p++) if (mask[p]) begin
      int t;
      seen++;
      t = (plen[p] > 15) ? 15 : plen[p];
      q_beat.push_back({1'b0, seen == cnt, 31'd0, 4'(t)});
      q_req.push_back({req, " R3/R4 data"});
    end
  endtask

  task automatic cluster(input logic [15:0] mask, input logic [11:0] bc, input bit keep, input string req);
    int maxl = 0;
    for (int p = 0; p < 16; p++) if (mask[p] && plen[p] > maxl) maxl = plen[p];
    if (keep) expect_pkt(mask, bc, req);
    @(posedge clk); #1;
    bcid = bc; hit = mask;
    for (int n = 1; n <= maxl; n++) begin
      @(posedge clk); #1;
      bcid = ~bc;
      for (int p = 0; p < 16; p++) if (mask[p] && plen[p] == n) hit[p] = 1'b0;
    end
    @(posedge clk); #1;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 400 && q_beat.size() != 0; i++) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
    chk(q_beat.size() == 0, {req, " all expected beats seen"}, 64'(q_beat.size()), 64'd0);
    @(negedge clk);
    chk(!valid, {req, " idle after drain"}, 64'(valid), 64'd0);
  endtask

  task automatic chk_lost(input logic [7:0] e, input string req);
    @(negedge clk);
    chk(lost == e, req, 64'(lost), 64'(e));
  endtask

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!valid, "R1 valid after reset", 64'(valid), 64'd0);
    chk(lost == 0, "R1 lost after reset", 64'(lost), 64'd0);

    // single pixel, merge off, row-0 pixel
    plen[3] = 5;
    cluster(16'h0008, 12'h123, 1, "R2 single");
    drain("R2");

    // saturation, merge on with row-0 hit
    merge_en = 1;
    plen[0] = 7; plen[5] = 2; plen[15] = 20;
    cluster(16'h8021, 12'hABC, 1, "R3 sat R9 flag");
    drain("R3");

    // no row-0 hit, random backpressure
    rmode = 2;
    plen[9] = 3; plen[10] = 4;
    cluster(16'h0600, 12'h0F0, 1, "R9 noflag R11");
    drain("R11");
    rmode = 0;

    // late strobe during open cluster
    plen[1] = 6;
    expect_pkt(16'h0002, 12'h321, "R5 late");
    @(posedge clk); #1; bcid = 12'h321; hit = 16'h0002;
    for (int n = 1; n <= 6; n++) begin
      @(posedge clk); #1;
      bcid = 12'h000;
      if (n == 1) hit[8] = 1'b1;
      if (n == 3) hit[8] = 1'b0;
      if (n == 6) hit[1] = 1'b0;
    end
    @(posedge clk);
    drain("R5");
    chk_lost(8'd0, "R5 late strobe not lost");

    // threshold
    thr = 5'd2;
    plen[4] = 2; plen[6] = 3; plen[12] = 4;
    cluster(16'h1050, 12'h777, 0, "R6 over");
    drain("R6 over");
    chk_lost(8'd1, "R10 R6 drop counted");
    plen[4] = 2; plen[6] = 3;
    cluster(16'h0050, 12'h778, 1, "R6 equal");
    drain("R6 equal");
    thr = 5'd16;

    // dead state and order
    rmode = 1;
    plen[2] = 2;  cluster(16'h0004, 12'h101, 1, "R8 first");
    plen[7] = 3;  cluster(16'h0080, 12'h102, 1, "R8 second");
    plen[11] = 2; cluster(16'h0800, 12'h103, 0, "R7 dead");
    chk_lost(8'd2, "R10 R7 drop counted");
    @(negedge clk);
    chk(valid && hdr && data[15:0] == 16'h0004, "R8 head is oldest", {28'd0, data}, 64'h4);
    rmode = 0;
    drain("R8");
    plen[13] = 3; cluster(16'h2000, 12'h104, 1, "R8 slot freed");
    drain("R8 freed");
    chk_lost(8'd2, "R10 stable");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule